// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block sits between a byte-wide register port and one serial NOR flash device on a single-bit SPI link. Software loads the address, the write data, a bit count or a six-byte program bank, and then sets one trigger bit in the command register. The sequencer runs the matching flash transaction by itself. That transaction is a byte read, a status read, a byte program, a status write, or a raw shift of the top N bank bits. The trigger bit reads back as set while the work is in progress. Hardware clears it when the transaction and its trailing chip-select gap have finished, so software polls the command register for zero.

The serial clock runs at half the system clock in SPI mode 0. Write-protect and hold stay high. A two-transaction operation (byte program, status write) sends a write-enable transaction first. Chip select rises between the two transactions and is held high for a minimum gap. Triggers have no effect until the unlock register holds the enable key.

Top module: `norctl_top`

## Requirements
- R1: After reset, and whenever no transaction runs, sfCsN is 1 and sfClk is 0. sfWpN and sfHoldN are always 1. sfMosi changes only while sfClk is low (SPI mode 0), and sfClk never pulses while sfCsN is high.
- R2: The unlock register (offset 14) reads 1 only after it was last written with 0x30. Any other value written there locks again. While locked, a command write starts no transaction and the command register stays 0.
- R3: The command register (offset 0) holds one-hot triggers: bit 0 read, bit 1 status read, bit 2 raw shift, bit 4 byte program, bit 5 status write, bit 7 auto-increment. While an operation runs, only its trigger bit reads as 1, and bit 7 always reads 0. The register returns to 0 when the operation completes.
- R4: A read sends 0x03 and the 24-bit address, MSB first, in a 40-clock transaction. The last 8 bits received land in the read-data register (offset 3).
- R5: A status read sends 0x05 in a 16-clock transaction. The 8 bits received after the opcode land in the status register (offset 2).
- R6: A byte program sends a lone 0x06 transaction, then a 40-clock transaction of 0x02, the 24-bit address and the write-data byte (offset 7).
- R7: A status write sends a lone 0x06 transaction, then a 16-clock transaction of 0x01 followed by the write-data byte.
- R8: A raw shift sends the top N bits of the bank, MSB first, from bank byte 5 (offset 13) down to bank byte 0 (offset 8). N is the count register (offset 1). N=8 sends byte 5 alone, and N=32 sends bytes 5 to 2.
- R9: A raw shift with N=0 produces no transaction and completes. N above 48 is treated as 48.
- R10: The address registers are low (offset 4), middle (offset 5) and high (offset 6). When bit 7 accompanies a read or byte-program trigger, the 24-bit address advances by one after completion and wraps from 0xFFFFFF to 0. Other operations leave the address unchanged.
- R11: Between two consecutive transactions, sfCsN stays high for at least 4 system cycles, which is two serial clocks.
- R12: A command write while an operation is busy is ignored. If several trigger bits are written together, only the lowest-numbered one runs.
- R13: All registers are byte-wide and read back at their offsets. The count and the bank bytes read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| sfClk | output | 1 | Serial clock to flash |
| sfCsN | output | 1 | Active-low chip select |
| sfMosi | output | 1 | Serial data to flash |
| sfMiso | input | 1 | Serial data from flash |
| sfWpN | output | 1 | Write-protect, held high |
| sfHoldN | output | 1 | Hold, held high |

## Verification
The bench drives a behavioural flash model that logs every chip-select window, so it sees bit counts, opcode order and data bytes directly. It targets the raw-shift edges: a zero count must produce no chip-select window at all, and a count above the bank size must be clamped to 48 bits. A design that got either wrong would send stray or short bit streams. It checks the address wrap at 0xFFFFFF and checks that auto-increment is ignored by status operations, where a faulty design would leave a carry in the high byte or move the address. Command writes while busy, multi-bit triggers and triggers before unlock must all leave the link quiet. A faulty design here would start a second or unexpected transaction that shows up in the log.

// File: rtl/norctl_pkg.sv
`timescale 1ns/1ps
package norctl_pkg;

  // command register bit positions
  localparam int CMD_RD  = 0;
  localparam int CMD_RS  = 1;
  localparam int CMD_PRG = 2;
  localparam int CMD_WR  = 4;
  localparam int CMD_WS  = 5;
  localparam int CMD_INC = 7;

  // register offsets
  localparam logic [3:0] REG_CMD    = 4'd0;
  localparam logic [3:0] REG_CNT    = 4'd1;
  localparam logic [3:0] REG_FSTAT  = 4'd2;
  localparam logic [3:0] REG_RDATA  = 4'd3;
  localparam logic [3:0] REG_ADR0   = 4'd4;
  localparam logic [3:0] REG_ADR1   = 4'd5;
  localparam logic [3:0] REG_ADR2   = 4'd6;
  localparam logic [3:0] REG_WDATA  = 4'd7;
  localparam int         REG_BANK0  = 8;
  localparam logic [3:0] REG_UNLOCK = 4'd14;

  localparam logic [7:0] UNLOCK_KEY = 8'h30;

  // flash opcodes
  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_PP   = 8'h02;
  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_WREN = 8'h06;

  typedef enum logic [2:0] {
    SEG_READ, SEG_RDSR, SEG_WREN, SEG_PP, SEG_WRSR, SEG_RAW
  } segKind_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_RD, OP_RS, OP_PRG, OP_WR, OP_WS
  } opSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    segKind_e kind;
    logic     shift;
    logic     capRd;
    logic     capSr;
    logic     incAddr;
  } dpCtl_t;

endpackage

// File: rtl/norctl_dp.sv
`timescale 1ns/1ps
module norctl_dp
  import norctl_pkg::*;
#(
  parameter int BANK_BYTES = 6,
  parameter int SHIFT_W    = 48,
  parameter int CNT_W      = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [3:0]       regAddr,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  input  dpCtl_t           ctl,
  input  logic [7:0]       cmdView,
  input  logic             miso,
  output logic             mosi,
  output logic             lastBit,
  output logic             rawZero,
  output logic             unlocked
);

  localparam int BANK_W = BANK_BYTES * 8;

  logic [7:0]         cntReg, fstatReg, rdataReg, wdataReg;
  logic [23:0]        addrReg;
  logic [7:0]         bank [BANK_BYTES];
  logic [BANK_W-1:0]  bankFlat;
  logic [SHIFT_W-1:0] txSh, loadVal;
  logic [7:0]         rxSh;
  logic [CNT_W-1:0]   bitsLeft, loadBits, rawBits;

  // program bank, one register per byte; byte BANK_BYTES-1 is the MSB end
  for (genvar g = 0; g < BANK_BYTES; g++) begin : gBank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bank[g] <= '0;
      else if (regWe && regAddr == 4'(REG_BANK0 + g))
        bank[g] <= regWdata;
    end
    assign bankFlat[g*8 +: 8] = bank[g];
  end

  assign rawBits = (int'(cntReg) > BANK_W) ? CNT_W'(BANK_W) : CNT_W'(cntReg);
  assign rawZero = (rawBits == '0);

  // segment image, left-aligned in the shifter
  always_comb begin
    loadVal  = '0;
    loadBits = '0;
    unique case (ctl.kind)
      SEG_READ: begin
        loadVal[SHIFT_W-1 -: 40] = {OPC_READ, addrReg, 8'h00};
        loadBits = CNT_W'(40);
      end
      SEG_RDSR: begin
        loadVal[SHIFT_W-1 -: 16] = {OPC_RDSR, 8'h00};
        loadBits = CNT_W'(16);
      end
      SEG_WREN: begin
        loadVal[SHIFT_W-1 -: 8] = OPC_WREN;
        loadBits = CNT_W'(8);
      end
      SEG_PP: begin
        loadVal[SHIFT_W-1 -: 40] = {OPC_PP, addrReg, wdataReg};
        loadBits = CNT_W'(40);
      end
      SEG_WRSR: begin
        loadVal[SHIFT_W-1 -: 16] = {OPC_WRSR, wdataReg};
        loadBits = CNT_W'(16);
      end
      SEG_RAW: begin
        loadVal[SHIFT_W-1 -: BANK_W] = bankFlat;
        loadBits = rawBits;
      end
      default: begin
        loadVal  = '0;
        loadBits = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh     <= '0;
      rxSh     <= '0;
      bitsLeft <= '0;
    end else if (ctl.load) begin
      txSh     <= loadVal;
      bitsLeft <= loadBits;
    end else if (ctl.shift) begin
      txSh     <= txSh << 1;
      rxSh     <= {rxSh[6:0], miso};
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  assign mosi    = txSh[SHIFT_W-1];
  assign lastBit = (bitsLeft == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg   <= '0;
      fstatReg <= '0;
      rdataReg <= '0;
      wdataReg <= '0;
      addrReg  <= '0;
      unlocked <= 1'b0;
    end else begin
      if (ctl.capRd)   rdataReg <= rxSh;
      if (ctl.capSr)   fstatReg <= rxSh;
      if (ctl.incAddr) addrReg  <= addrReg + 24'd1;
      if (regWe) begin
        unique case (regAddr)
          REG_CNT:    cntReg         <= regWdata;
          REG_ADR0:   addrReg[7:0]   <= regWdata;
          REG_ADR1:   addrReg[15:8]  <= regWdata;
          REG_ADR2:   addrReg[23:16] <= regWdata;
          REG_WDATA:  wdataReg       <= regWdata;
          REG_UNLOCK: unlocked       <= (regWdata == UNLOCK_KEY);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      REG_CMD:    regRdata = cmdView;
      REG_CNT:    regRdata = cntReg;
      REG_FSTAT:  regRdata = fstatReg;
      REG_RDATA:  regRdata = rdataReg;
      REG_ADR0:   regRdata = addrReg[7:0];
      REG_ADR1:   regRdata = addrReg[15:8];
      REG_ADR2:   regRdata = addrReg[23:16];
      REG_WDATA:  regRdata = wdataReg;
      REG_UNLOCK: regRdata = {7'd0, unlocked};
      default: begin
        for (int i = 0; i < BANK_BYTES; i++)
          if (regAddr == 4'(REG_BANK0 + i)) regRdata = bank[i];
      end
    endcase
  end

  // R10
  addr_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.incAddr && !(regWe && (regAddr == REG_ADR0 || regAddr == REG_ADR1 || regAddr == REG_ADR2)))
    |=> addrReg == $past(addrReg) + 24'd1);

  // R8
  no_empty_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shift |-> bitsLeft != '0);

endmodule

// File: rtl/norctl_ctrl.sv
`timescale 1ns/1ps
module norctl_ctrl
  import norctl_pkg::*;
#(
  parameter int GAP_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [3:0] regAddr,
  input  logic [7:0] regWdata,
  input  logic       unlocked,
  input  logic       lastBit,
  input  logic       rawZero,
  output dpCtl_t     ctl,
  output logic [7:0] cmdView,
  output logic       sclk,
  output logic       csN
);

  localparam int GAP_W = $clog2(GAP_CYC + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_SHIFT, ST_SEGEND, ST_GAP, ST_FIN
  } state_e;

  state_e           st;
  opSel_e           op, reqOp;
  logic             incFlag, segIdx, sclkHigh, csNReg, accept, twoSeg;
  logic [GAP_W-1:0] gapCnt, csHighCnt;
  segKind_e         segKind;
  logic             unusedOk;

  assign unusedOk = ^{regWdata[3], regWdata[6]};

  // lowest-numbered trigger wins
  always_comb begin
    reqOp = OP_NONE;
    if      (regWdata[CMD_RD])  reqOp = OP_RD;
    else if (regWdata[CMD_RS])  reqOp = OP_RS;
    else if (regWdata[CMD_PRG]) reqOp = OP_PRG;
    else if (regWdata[CMD_WR])  reqOp = OP_WR;
    else if (regWdata[CMD_WS])  reqOp = OP_WS;
  end

  assign accept = regWe && regAddr == REG_CMD && unlocked &&
                  st == ST_IDLE && reqOp != OP_NONE;
  assign twoSeg = (op == OP_WR) || (op == OP_WS);

  always_comb begin
    unique case (op)
      OP_RD:   segKind = SEG_READ;
      OP_RS:   segKind = SEG_RDSR;
      OP_PRG:  segKind = SEG_RAW;
      OP_WR:   segKind = segIdx ? SEG_PP   : SEG_WREN;
      OP_WS:   segKind = segIdx ? SEG_WRSR : SEG_WREN;
      default: segKind = SEG_WREN;
    endcase
  end

  always_comb begin
    cmdView = '0;
    unique case (op)
      OP_RD:   cmdView[CMD_RD]  = 1'b1;
      OP_RS:   cmdView[CMD_RS]  = 1'b1;
      OP_PRG:  cmdView[CMD_PRG] = 1'b1;
      OP_WR:   cmdView[CMD_WR]  = 1'b1;
      OP_WS:   cmdView[CMD_WS]  = 1'b1;
      default: cmdView = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      op       <= OP_NONE;
      incFlag  <= 1'b0;
      segIdx   <= 1'b0;
      sclkHigh <= 1'b0;
      csNReg   <= 1'b1;
      gapCnt   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          op      <= reqOp;
          incFlag <= regWdata[CMD_INC];
          segIdx  <= 1'b0;
          st      <= (reqOp == OP_PRG && rawZero) ? ST_FIN : ST_LOAD;
        end
        ST_LOAD: begin
          csNReg   <= 1'b0;
          sclkHigh <= 1'b0;
          st       <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (!sclkHigh) sclkHigh <= 1'b1;
          else begin
            sclkHigh <= 1'b0;
            if (lastBit) st <= ST_SEGEND;
          end
        end
        ST_SEGEND: begin
          csNReg <= 1'b1;
          gapCnt <= '0;
          st     <= ST_GAP;
        end
        ST_GAP: begin
          if (gapCnt == GAP_W'(GAP_CYC - 1)) begin
            if (twoSeg && !segIdx) begin
              segIdx <= 1'b1;
              st     <= ST_LOAD;
            end else st <= ST_FIN;
          end else gapCnt <= gapCnt + 1'b1;
        end
        ST_FIN: begin
          op      <= OP_NONE;
          incFlag <= 1'b0;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.load    = (st == ST_LOAD);
    ctl.kind    = segKind;
    ctl.shift   = (st == ST_SHIFT) && sclkHigh;
    ctl.capRd   = (st == ST_SEGEND) && (op == OP_RD);
    ctl.capSr   = (st == ST_SEGEND) && (op == OP_RS);
    ctl.incAddr = (st == ST_FIN) && incFlag && (op == OP_RD || op == OP_WR);
  end

  assign sclk = sclkHigh;
  assign csN  = csNReg;

  // chip-select high time, saturating, for the gap check
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csHighCnt <= GAP_W'(GAP_CYC);
    else if (!csNReg) csHighCnt <= '0;
    else if (csHighCnt != GAP_W'(GAP_CYC)) csHighCnt <= csHighCnt + 1'b1;
  end

  // R3
  busy_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_IDLE) |-> ($onehot(cmdView) && !cmdView[CMD_INC]));

  // R2
  lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && !unlocked) |=> st == ST_IDLE);

  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_IDLE && st != ST_FIN) |=> op == $past(op));

  // R11
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csNReg) |-> csHighCnt >= GAP_W'(GAP_CYC));

  // R1
  sclk_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclkHigh |-> !csNReg);

endmodule

// File: rtl/norctl_top.sv
`timescale 1ns/1ps
module norctl_top
  import norctl_pkg::*;
#(
  parameter int BANK_BYTES = 6,
  parameter int GAP_CYC    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [3:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       sfClk,
  output logic       sfCsN,
  output logic       sfMosi,
  input  logic       sfMiso,
  output logic       sfWpN,
  output logic       sfHoldN
);

  localparam int SHIFT_W = (BANK_BYTES * 8 > 40) ? BANK_BYTES * 8 : 40;
  localparam int CNT_W   = $clog2(SHIFT_W + 1);

  dpCtl_t     ctl;
  logic [7:0] cmdView;
  logic       lastBit, rawZero, unlocked;

  norctl_ctrl #(.GAP_CYC(GAP_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .unlocked(unlocked), .lastBit(lastBit),
    .rawZero(rawZero), .ctl(ctl), .cmdView(cmdView),
    .sclk(sfClk), .csN(sfCsN)
  );

  norctl_dp #(.BANK_BYTES(BANK_BYTES), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .ctl(ctl), .cmdView(cmdView),
    .miso(sfMiso), .mosi(sfMosi), .lastBit(lastBit), .rawZero(rawZero),
    .unlocked(unlocked)
  );

  assign sfWpN   = 1'b1;
  assign sfHoldN = 1'b1;

  // R1
  mode0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sfCsN && sfClk) |-> $stable(sfMosi));

endmodule

// File: tb/test_norctl_top.sv
`timescale 1ns/1ps
module test_norctl_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       sfClk, sfCsN, sfMosi, sfWpN, sfHoldN;
  logic       sfMiso;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  norctl_top i_norctl_top (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sfClk(sfClk), .sfCsN(sfCsN),
    .sfMosi(sfMosi), .sfMiso(sfMiso), .sfWpN(sfWpN), .sfHoldN(sfHoldN)
  );

  // ---------------- flash model ----------------
  logic [7:0]  fMem [256];
  logic [7:0]  fStat = 8'h00;
  logic [7:0]  fOp = 8'h00;
  logic [23:0] fAddr = '0;
  logic [63:0] fIn = '0;
  int          fBit = 0;
  bit          fWel = 0;
  logic        fMiso = 1'b0;
  int          txCount = 0;
  int          logBits [16];
  logic [63:0] logVal [16];
  int          hc = 100;
  bit          prevCs = 1'b1;
  int          gapBad = 0;

  assign sfMiso = fMiso;

  always @(negedge sfCsN) begin
    fBit = 0;
    fIn  = '0;
  end

  always @(posedge sfClk) if (!sfCsN) begin
    fIn = {fIn[62:0], sfMosi};
    fBit++;
    if (fBit == 8)  fOp = fIn[7:0];
    if (fBit == 32) fAddr = fIn[23:0];
  end

  always @(negedge sfClk) if (!sfCsN) begin
    if (fOp == 8'h03 && fBit >= 32 && fBit < 40)
      fMiso = fMem[fAddr[7:0]][39 - fBit];
    else if (fOp == 8'h05 && fBit >= 8 && fBit < 16)
      fMiso = fStat[15 - fBit];
    else
      fMiso = 1'b0;
  end

  always @(posedge sfCsN) begin
    if (fBit != 0) begin
      logBits[txCount % 16] = fBit;
      logVal[txCount % 16]  = fIn;
      txCount++;
      if (fBit == 8 && fIn[7:0] == 8'h06) fWel = 1;
      else if (fBit == 40 && fIn[39:32] == 8'h02 && fWel) begin
        fMem[fIn[15:8]] = fIn[7:0];
        fWel = 0;
      end else if (fBit == 16 && fIn[15:8] == 8'h01 && fWel) begin
        fStat = fIn[7:0];
        fWel = 0;
      end
    end
    fBit = 0;
    fOp  = 8'h00;
  end

  // chip-select high-time monitor
  always @(posedge clk) begin
    if (sfCsN) hc++;
    else begin
      if (prevCs && hc < 4) gapBad++;
      hc = 0;
    end
    prevCs = sfCsN;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitDone(input string req);
    logic [7:0] v;
    v = 8'hFF;
    for (int i = 0; i < 3000 && v != 8'h00; i++) rd(4'd0, v);
    chk(req, v, 8'h00);
  endtask

  task automatic setAddr(input logic [23:0] a);
    wr(4'd4, a[7:0]); wr(4'd5, a[15:8]); wr(4'd6, a[23:16]);
  endtask

  task automatic getAddr(output logic [23:0] a);
    logic [7:0] b0, b1, b2;
    rd(4'd4, b0); rd(4'd5, b1); rd(4'd6, b2);
    a = {b2, b1, b0};
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    logic [7:0] v;
    chk("R1 csN idle", sfCsN, 1);
    chk("R1 sclk idle", sfClk, 0);
    chk("R1 wp/hold", {sfWpN, sfHoldN}, 2'b11);
    rd(4'd0, v); chk("R3 cmd reset", v, 0);
    rd(4'd14, v); chk("R2 locked at reset", v, 0);
  endtask

  task automatic t_locked;
    int t0; logic [7:0] v;
    t0 = txCount;
    wr(4'd0, 8'h01);
    repeat (60) @(negedge clk);
    chk("R2 no tx while locked", txCount, t0);
    rd(4'd0, v); chk("R2 cmd stays 0", v, 0);
  endtask

  task automatic t_unlock;
    logic [7:0] v;
    wr(4'd14, 8'h30);
    rd(4'd14, v); chk("R2 unlocked", v, 1);
  endtask

  task automatic t_read_inc;
    int t0; logic [7:0] v; logic [23:0] a;
    fMem[8'h12] = 8'h9E;
    setAddr(24'h000012);
    t0 = txCount;
    wr(4'd0, 8'h81);
    rd(4'd0, v); chk("R3 busy view read", v, 8'h01);
    waitDone("R3 read completes");
    rd(4'd3, v); chk("R4 read data", v, 8'h9E);
    chk("R4 tx count", txCount, t0 + 1);
    chk("R4 bits", logBits[t0 % 16], 40);
    chk("R4 frame", logVal[t0 % 16], 64'h03_000012_00);
    getAddr(a); chk("R10 addr inc", a, 24'h000013);
  endtask

  task automatic t_read_noinc;
    logic [7:0] v; logic [23:0] a;
    fMem[8'h40] = 8'h3C;
    setAddr(24'h000040);
    wr(4'd0, 8'h01);
    waitDone("R3 read completes");
    rd(4'd3, v); chk("R4 read data 2", v, 8'h3C);
    getAddr(a); chk("R10 addr held", a, 24'h000040);
  endtask

  task automatic t_status;
    int t0; logic [7:0] v;
    fStat = 8'hA5;
    t0 = txCount;
    wr(4'd0, 8'h02);
    waitDone("R3 status completes");
    rd(4'd2, v); chk("R5 status byte", v, 8'hA5);
    chk("R5 bits", logBits[t0 % 16], 16);
    chk("R5 opcode", logVal[t0 % 16], 64'h0500);
  endtask

  task automatic t_program;
    int t0, g0; logic [23:0] a;
    wr(4'd7, 8'h5C);
    setAddr(24'h000020);
    t0 = txCount; g0 = gapBad;
    wr(4'd0, 8'h90);
    waitDone("R3 program completes");
    chk("R6 two tx", txCount, t0 + 2);
    chk("R6 wren bits", logBits[t0 % 16], 8);
    chk("R6 wren", logVal[t0 % 16], 64'h06);
    chk("R6 pp bits", logBits[(t0 + 1) % 16], 40);
    chk("R6 pp frame", logVal[(t0 + 1) % 16], 64'h02_000020_5C);
    chk("R6 mem", fMem[8'h20], 8'h5C);
    getAddr(a); chk("R10 addr inc program", a, 24'h000021);
    chk("R11 cs gap", gapBad, g0);
  endtask

  task automatic t_wrstatus;
    int t0; logic [23:0] a0, a1;
    wr(4'd7, 8'h1C);
    getAddr(a0);
    t0 = txCount;
    wr(4'd0, 8'hA0);
    waitDone("R3 wrstatus completes");
    chk("R7 wren", logVal[t0 % 16], 64'h06);
    chk("R7 bits", logBits[(t0 + 1) % 16], 16);
    chk("R7 frame", logVal[(t0 + 1) % 16], 64'h011C);
    chk("R7 flash status", fStat, 8'h1C);
    getAddr(a1); chk("R10 no inc on status write", a1, a0);
  endtask

  task automatic t_raw;
    int t0; logic [7:0] v;
    wr(4'd13, 8'h06); wr(4'd1, 8'd8);
    rd(4'd1, v); chk("R13 count readback", v, 8'd8);
    rd(4'd13, v); chk("R13 bank readback", v, 8'h06);
    t0 = txCount;
    wr(4'd0, 8'h04);
    waitDone("R3 raw completes");
    chk("R8 n8 bits", logBits[t0 % 16], 8);
    chk("R8 n8 value", logVal[t0 % 16], 64'h06);
    wr(4'd13, 8'h20); wr(4'd12, 8'h00); wr(4'd11, 8'h10); wr(4'd10, 8'h00);
    wr(4'd9, 8'hFF); wr(4'd8, 8'hFF); wr(4'd1, 8'd32);
    t0 = txCount;
    wr(4'd0, 8'h04);
    waitDone("R3 raw completes");
    chk("R8 n32 bits", logBits[t0 % 16], 32);
    chk("R8 n32 value", logVal[t0 % 16], 64'h20001000);
  endtask

  task automatic t_raw_edges;
    int t0;
    wr(4'd1, 8'd0);
    t0 = txCount;
    wr(4'd0, 8'h04);
    waitDone("R9 zero count completes");
    repeat (10) @(negedge clk);
    chk("R9 zero count no tx", txCount, t0);
    for (int i = 0; i < 6; i++) wr(4'(8 + i), 8'(8'h11 * (i + 1)));
    wr(4'd1, 8'd60);
    t0 = txCount;
    wr(4'd0, 8'h04);
    waitDone("R9 clamp completes");
    chk("R9 clamp bits", logBits[t0 % 16], 48);
    chk("R9 clamp value", logVal[t0 % 16], 64'h665544332211);
  endtask

  task automatic t_busy;
    int t0; logic [7:0] r0, v;
    rd(4'd3, r0);
    fStat = 8'h77;
    t0 = txCount;
    wr(4'd0, 8'h02);
    wr(4'd0, 8'h01);
    waitDone("R12 busy op completes");
    repeat (20) @(negedge clk);
    chk("R12 one tx only", txCount, t0 + 1);
    rd(4'd3, v); chk("R12 read data untouched", v, r0);
    rd(4'd2, v); chk("R5 status 77", v, 8'h77);
  endtask

  task automatic t_priority;
    int t0;
    setAddr(24'h000012);
    t0 = txCount;
    wr(4'd0, 8'h03);
    waitDone("R12 priority completes");
    chk("R12 single tx", txCount, t0 + 1);
    chk("R12 read chosen", logBits[t0 % 16], 40);
  endtask

  task automatic t_wrap;
    logic [7:0] v; logic [23:0] a;
    fMem[8'hFF] = 8'h42;
    setAddr(24'hFFFFFF);
    wr(4'd0, 8'h81);
    waitDone("R3 wrap read completes");
    rd(4'd3, v); chk("R4 read at top", v, 8'h42);
    getAddr(a); chk("R10 wrap", a, 24'h000000);
  endtask

  task automatic t_relock;
    int t0; logic [7:0] v;
    wr(4'd14, 8'h31);
    rd(4'd14, v); chk("R2 relocked", v, 0);
    t0 = txCount;
    wr(4'd0, 8'h02);
    repeat (60) @(negedge clk);
    chk("R2 no tx after relock", txCount, t0);
    rd(4'd0, v); chk("R2 cmd 0 after relock", v, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) fMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_locked();
    t_unlock();
    t_read_inc();
    t_read_noinc();
    t_status();
    t_program();
    t_wrstatus();
    t_raw();
    t_raw_edges();
    t_busy();
    t_priority();
    t_wrap();
    t_relock();
    chk("R11 cs gap overall", gapBad, 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule